// File: doc/BRIEF.md
# Timing-Matched Pattern Output Sequencer

This block keeps a schedule of output events for a servo or head-switching controller. Software loads pairs into two queues of ten entries each. A pair is a 16-bit compare time and an output pattern. The block watches a free 16-bit timer supplied from outside. When the compare time of the current entry equals the timer, the paired pattern is loaded into the pattern output register. The sequencer then moves on to the next entry. Bit 0 of the pattern is meant to carry the head-switching signal, and the other bits carry servo control flags.

There are two consumption modes. In single mode an entry is removed once it has fired, and the block goes quiet when nothing is left. In loop mode the entries are kept, and the read position wraps back to the first stored entry. The schedule can use the first queue alone (ten stages) or the first queue followed by the second (twenty stages). Two start strobes come from the reference generator. Each one places the read position on the first entry of its own queue.

Top module: `pattern_fifo_seq`

## Requirements
- R1: After reset, `pat_out`, both levels and both overflow flags are zero.
- R2: A pulse on `wr1` or `wr2` appends the pair (`wr_time`, `wr_pat`) to queue 1 or queue 2. The matching level output rises by one on the next clock edge. Each queue holds at most DEPTH (10) entries.
- R3: A write to a full queue is discarded, and that queue's overflow flag sets and stays set until reset. The contents and level of the full queue do not change.
- R4: In a cycle with no effective start strobe, if the current entry's compare time equals `timer`, `pat_out` takes that entry's pattern at the next clock edge. At all other times `pat_out` holds its value.
- R5: In single mode (`loop_mode`=0), the entry that fired is removed and its queue level drops by one. The next entry becomes current. At most one entry fires per clock cycle.
- R6: In single mode, once the active queue is empty no further pattern is output. Writing a new entry to that queue resumes operation.
- R7: In loop mode (`loop_mode`=1), entries are never removed. After the last stored entry of the active queue fires, the position advances to that queue's first entry.
- R8: With `dual`=1, queue 1 runs first and queue 2 follows. In single mode the block moves to queue 2 when queue 1 drains. In loop mode it moves to queue 2 after the last entry of queue 1, and back to queue 1 after the last entry of queue 2.
- R9: With `dual`=0, only queue 1 is used. Entries of queue 2 never reach `pat_out`, and `start2` has no effect.
- R10: `start1` sets the position to the first entry of queue 1. `start2` (with `dual`=1) sets it to the first entry of queue 2. `start1` wins over `start2`. In a cycle carrying an effective start, no match fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr1 | input | 1 | Append a pair to queue 1 |
| wr2 | input | 1 | Append a pair to queue 2 |
| wr_time | input | TW | Compare time of the pair being written |
| wr_pat | input | PW | Output pattern of the pair being written |
| loop_mode | input | 1 | 0 = single (consume), 1 = loop (replay) |
| dual | input | 1 | 1 = twenty stages (queue 1 then queue 2), 0 = queue 1 only |
| start1 | input | 1 | Restart at first entry of queue 1 |
| start2 | input | 1 | Restart at first entry of queue 2 (twenty-stage only) |
| timer | input | TW | Running timer value to compare against |
| pat_out | output | PW | Pattern output register |
| level1 | output | $clog2(DEPTH+1) | Valid entries in queue 1 |
| level2 | output | $clog2(DEPTH+1) | Valid entries in queue 2 |
| ovf1 | output | 1 | Sticky overflow of queue 1 |
| ovf2 | output | 1 | Sticky overflow of queue 2 |

## Verification
The bench fills queue 2 past capacity and then drains it. If the eleventh write leaked in, a pattern would appear where none should be. A timer value that equals a later entry but not the current head must not fire; a design that searched the whole queue would emit out of order. In two scenarios the timer is held on the same value: after a pop, so that a design that reused the old head would repeat a pattern, and after the queue is empty, so that a design that did not stop would replay stale data. Start strobes are pulsed together with a matching timer, and the hand-off between the two queues is exercised in both modes. Each of these would show up as a wrong `pat_out` or level against the bench's queue model.

// File: rtl/pattern_fifo_seq.sv
module pattern_fifo_seq #(
  parameter int DEPTH = 10,
  parameter int TW    = 16,
  parameter int PW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr1,
  input  logic                       wr2,
  input  logic [TW-1:0]              wr_time,
  input  logic [PW-1:0]              wr_pat,
  input  logic                       loop_mode,
  input  logic                       dual,
  input  logic                       start1,
  input  logic                       start2,
  input  logic [TW-1:0]              timer,
  output logic [PW-1:0]              pat_out,
  output logic [$clog2(DEPTH+1)-1:0] level1,
  output logic [$clog2(DEPTH+1)-1:0] level2,
  output logic                       ovf1,
  output logic                       ovf2
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] b, input logic [CW-1:0] o);
    logic [AW:0] s;
    s = (AW+1)'(b) + (AW+1)'(o);
    return (s >= (AW+1)'(DEPTH)) ? AW'(s - (AW+1)'(DEPTH)) : AW'(s);
  endfunction

  logic [1:0][TW-1:0] rd_t;
  logic [1:0][PW-1:0] rd_p;
  logic [1:0][CW-1:0] lvl;
  logic [1:0]         ovf_v;
  logic [AW-1:0]      rp;
  logic               sel;

  wire          act  = dual & sel;
  wire          strt = start1 | (start2 & dual);
  wire [CW-1:0] off  = loop_mode ? CW'(rp) : '0;
  wire          hit  = !strt && (off < lvl[act]) && (rd_t[act] == timer);

  for (genvar f = 0; f < 2; f++) begin : g_q
    logic [TW-1:0] tmem [DEPTH];
    logic [PW-1:0] pmem [DEPTH];
    logic [AW-1:0] hd;
    logic [CW-1:0] cnt;
    logic          ovf;
    wire           wr   = (f == 0) ? wr1 : wr2;
    wire           push = wr && (cnt < CW'(DEPTH));
    wire           pop  = hit && !loop_mode && (act == 1'(f));
    wire [AW-1:0]  tail = wrap(hd, cnt);
    wire [AW-1:0]  rdi  = wrap(hd, off);

    always_ff @(posedge clk)
      if (push) begin
        tmem[tail] <= wr_time;
        pmem[tail] <= wr_pat;
      end

    always_ff @(posedge clk)
      if (!rst_n) begin
        hd  <= '0;
        cnt <= '0;
        ovf <= 1'b0;
      end else begin
        cnt <= cnt + CW'(push) - CW'(pop);
        if (pop) hd <= wrap(hd, CW'(1));
        ovf <= ovf | (wr & ~push);
      end

    assign rd_t[f]  = tmem[rdi];
    assign rd_p[f]  = pmem[rdi];
    assign lvl[f]   = cnt;
    assign ovf_v[f] = ovf;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      rp      <= '0;
      sel     <= 1'b0;
      pat_out <= '0;
    end else if (strt) begin
      rp  <= '0;
      sel <= !start1;
    end else if (hit) begin
      pat_out <= rd_p[act];
      if (loop_mode) begin
        if (CW'(rp) + CW'(1) < lvl[act]) rp <= rp + AW'(1);
        else begin
          rp  <= '0;
          sel <= dual && !act;
        end
      end else if (lvl[act] == CW'(1) && dual && !act) begin
        sel <= 1'b1;
      end
    end

  assign level1 = lvl[0];
  assign level2 = lvl[1];
  assign ovf1   = ovf_v[0];
  assign ovf2   = ovf_v[1];

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (level1 <= CW'(DEPTH)) && (level2 <= CW'(DEPTH))); // R2
  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1 && level1 == CW'(DEPTH)) |=> ovf1); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf1 || ovf2) |=> ($past(ovf1) -> ovf1) && ($past(ovf2) -> ovf2)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(pat_out)); // R4
  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !loop_mode && !act && !wr1) |=> level1 == CW'($past(level1) - 1'b1)); // R5
  AST_LOOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && !wr1 && !wr2) |=> $stable(level1) && $stable(level2)); // R7
  AST_START_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    strt |=> $stable(pat_out)); // R10
endmodule

// File: tb/tb_pattern_fifo_seq.sv
`timescale 1ns/1ps
module tb_pattern_fifo_seq;
  logic clk = 0, rst_n = 0;
  logic wr1 = 0, wr2 = 0, loop_mode = 0, dual = 0, start1 = 0, start2 = 0;
  logic [15:0] wr_time = 0, timer = 16'hFFFF;
  logic [7:0]  wr_pat = 0;
  logic [7:0]  pat_out;
  logic [3:0]  level1, level2;
  logic        ovf1, ovf2;
  int errs = 0, checks = 0;
  bit done = 0;

  typedef struct { logic [15:0] t; logic [7:0] p; } ent_t;
  ent_t q1[$], q2[$];
  int mpos; bit msel, mo1, mo2; logic [7:0] mpat;

  always #2.5 clk = ~clk;

  pattern_fifo_seq dut (.clk, .rst_n, .wr1, .wr2, .wr_time, .wr_pat, .loop_mode, .dual,
    .start1, .start2, .timer, .pat_out, .level1, .level2, .ovf1, .ovf2);

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    q1.delete(); q2.delete(); mpos = 0; msel = 0; mo1 = 0; mo2 = 0; mpat = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic step();
    bit act, strt, hit; int sz, off; ent_t hq[$];
    act = dual & msel;
    hq = act ? q2 : q1; sz = hq.size();
    off = loop_mode ? mpos : 0;
    strt = start1 | (start2 & dual);
    hit = !strt && off < sz && hq[off].t == timer;
    if (wr1) begin if (q1.size() < 10) q1.push_back('{wr_time, wr_pat}); else mo1 = 1; end
    if (wr2) begin if (q2.size() < 10) q2.push_back('{wr_time, wr_pat}); else mo2 = 1; end
    if (strt) begin mpos = 0; msel = !start1; end
    else if (hit) begin
      mpat = hq[off].p;
      if (loop_mode) begin
        if (off + 1 < sz) mpos++;
        else begin mpos = 0; msel = dual && !act; end
      end else begin
        if (act) void'(q2.pop_front()); else void'(q1.pop_front());
        if (sz == 1 && dual && !act) msel = 1;
      end
    end
    @(posedge clk); #1;
    chk("R4 pat_out", pat_out, mpat);
    chk("R2 level1", level1, q1.size());
    chk("R2 level2", level2, q2.size());
    chk("R3 ovf1", ovf1, mo1);
    chk("R3 ovf2", ovf2, mo2);
    wr1 = 0; wr2 = 0; start1 = 0; start2 = 0;
  endtask

  task automatic put(int f, int t, int p);
    timer = 16'hFFFF; wr_time = 16'(t); wr_pat = 8'(p);
    if (f == 1) wr1 = 1; else wr2 = 1;
    step();
  endtask

  task automatic tick(int t);
    timer = 16'(t); step();
  endtask

  initial begin
    #1;
    do_reset();
    chk("R1 pat_out", pat_out, 0); chk("R1 level1", level1, 0);
    chk("R1 level2", level2, 0); chk("R1 ovf", {ovf1, ovf2}, 0);

    put(1, 10, 8'hA1); put(1, 20, 8'hA2); put(1, 30, 8'hA3);
    chk("R2 three writes", level1, 3);
    tick(20); chk("R4 non-head no fire", pat_out, 0);
    tick(10); chk("R4 match", pat_out, 8'hA1); chk("R5 pop", level1, 2);
    tick(10); chk("R5 no repeat", pat_out, 8'hA1);
    tick(20); tick(30); chk("R5 drained", level1, 0);
    tick(30); tick(10); chk("R6 stopped", pat_out, 8'hA3);
    put(1, 40, 8'hB4); tick(40); chk("R6 resume", pat_out, 8'hB4);

    for (int i = 0; i < 11; i++) put(2, 100 + i, i);
    chk("R3 full level", level2, 10); chk("R3 ovf2 set", ovf2, 1); chk("R3 ovf1 clear", ovf1, 0);
    dual = 1; start2 = 1; tick(16'hFFFF);
    for (int i = 0; i < 10; i++) tick(100 + i);
    tick(110); chk("R3 dropped entry absent", pat_out, 9); chk("R3 drained", level2, 0);
    chk("R3 sticky", ovf2, 1);

    dual = 0; do_reset();
    put(1, 5, 8'h11); put(1, 6, 8'h22); put(2, 5, 8'h99);
    loop_mode = 1;
    tick(5); chk("R7 kept", level1, 2);
    tick(6); chk("R7 second", pat_out, 8'h22);
    start2 = 1; tick(5); chk("R9 start2 ignored", pat_out, 8'h11);
    tick(6); tick(5); chk("R7 wrap", pat_out, 8'h11); chk("R7 level", level1, 2);
    tick(5); chk("R9 queue2 unused", pat_out, 8'h11);
    dual = 1; start1 = 1; tick(0);
    tick(5); tick(6); chk("R8 queue1 end", pat_out, 8'h22);
    tick(5); chk("R8 loop to queue2", pat_out, 8'h99);
    tick(5); chk("R8 back to queue1", pat_out, 8'h11);
    tick(6);
    start2 = 1; tick(5); chk("R10 start blocks match", pat_out, 8'h22);
    tick(5); chk("R10 start2 position", pat_out, 8'h99);
    start1 = 1; tick(6); tick(6); chk("R10 start1 first entry", pat_out, 8'h99);
    tick(5); chk("R10 start1 fires head", pat_out, 8'h11);

    loop_mode = 0; do_reset(); dual = 1;
    put(1, 1, 8'h31); put(2, 2, 8'h32);
    tick(2); chk("R8 queue2 waits", pat_out, 0);
    tick(1); chk("R8 queue1 first", pat_out, 8'h31);
    tick(2); chk("R8 single handoff", pat_out, 8'h32); chk("R8 both empty", level1 + level2, 0);

    do_reset();
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 250 == 0) loop_mode = ~loop_mode;
      if ($urandom % 300 == 0) dual = ~dual;
      wr1 = ($urandom % 4 == 0); wr2 = ($urandom % 4 == 0);
      wr_time = 16'($urandom % 8); wr_pat = 8'($urandom);
      start1 = ($urandom % 20 == 0); start2 = ($urandom % 20 == 0);
      tick($urandom % 8);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule